// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bus-facing half of a byte-addressed serial memory slave on a two-wire, open-drain bus. It oversamples the clock and data lines on the system clock and cleans them with a synchronizer and a three-sample majority vote. From the cleaned lines it recognises start, repeated-start and stop conditions and shifts bytes in and out. It recognises its own select byte and pulls the data line low to acknowledge, or to send a zero data bit. Behind it sits a memory back end, which receives strobes for the address byte, for each written byte and for each stop. The back end supplies read bytes on request, can refuse a written byte (write protection), and can declare itself busy during an internal programming cycle. While the back end is busy the block does not answer.

The select byte carries a four-bit device-type code in bits 7:4, three selection bits in bits 3:1 and the direction in bit 0. `HW_BITS` of the selection bits, counted from bit 3 downward, are compared with the hardware address pins. The rest are not compared and are handed to the back end as page-block bits.

Top module: `twowire_slave_fe`

## Requirements
- R1: After reset the data-line enable `sda_oe` is low and no back-end strobe is issued until a start condition has been followed by a full select byte.
- R2: A stop condition (data rising while clock is high) returns the block to idle from any point, including in the middle of a byte, and leaves `sda_oe` low. `stop_ev` pulses for that stop only if the transfer had been selected.
- R3: The select byte is accepted when bits 7:4 equal `DEV_TYPE` (default 4'b1010) and the top `HW_BITS` bits of bits 3:1 equal the same bits of `hw_addr`. On acceptance the block pulls the data line low for the ninth clock and pulses `addr_valid` with `addr_rw` = bit 0 (1 = read) and `addr_sel` = bits 3:1. A byte that is not accepted gets no acknowledge and no strobe, and the block stays silent until the next start or stop.
- R4: The selection bits that are not compared are passed through on `addr_sel`, and both of their values are accepted.
- R5: In a write transfer, each byte after the select byte is shifted in MSB first, given to the back end with one `wr_valid` pulse on `wr_data`, and acknowledged in the ninth clock.
- R6: If `wr_refuse` is high in the cycle of `wr_valid`, that byte is not acknowledged. Later bytes are neither acknowledged nor strobed until a start or stop.
- R7: In a read transfer, `rd_req` pulses once per byte and `rd_data` is sampled in that cycle. The byte is sent MSB first, and the data line is released in the ninth clock. A master acknowledge leads to the next `rd_req` and byte. A master no-acknowledge ends the transfer: no further request, and the line stays released until a start or stop.
- R8: While `be_busy` is high, a select byte is neither acknowledged nor strobed.
- R9: A repeated start inside a transfer restarts select-byte reception without a `stop_ev` pulse.
- R10: Bytes clocked on the bus with no preceding start condition are not acknowledged.
- R11: `sda_oe` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line as seen on the wire (asynchronous) |
| hw_addr | input | 3 | Hardware address pins, compared with select bits 3:1 |
| be_busy | input | 1 | Back end busy; the block does not answer its select byte |
| wr_refuse | input | 1 | Back end refuses the byte strobed by `wr_valid` |
| rd_data | input | 8 | Read byte, sampled when `rd_req` is high |
| sda_oe | output | 1 | Pull the data line low when high (open-drain enable) |
| addr_valid | output | 1 | Select byte accepted |
| addr_rw | output | 1 | Direction of the accepted select byte, 1 = read |
| addr_sel | output | 3 | Selection bits 3:1 of the accepted select byte |
| wr_valid | output | 1 | Written byte complete on `wr_data` |
| wr_data | output | 8 | Received byte |
| rd_req | output | 1 | Request for the next read byte |
| stop_ev | output | 1 | Stop seen after a selected transfer |

## Verification
The bench acts as the bus master and drives single-byte writes and multi-byte writes. It also drives a current-address read and a random read through a repeated start, with the master both acknowledging and refusing read bytes. The matching select byte is compared with bytes that carry a wrong type code, a wrong hardware bit, or a flipped page bit. These cases separate the comparison of the type code from the comparison of the address pins, and show that the page bit is passed through. Write protection is exercised with a byte refused in mid-stream, and the busy flag with a select byte sent while busy. A bare byte with no start, and a stop dropped in the middle of a byte, show that the block ignores unframed traffic and aborts cleanly. A scoreboard compares every back-end strobe, with its data, against the sequence the master expects.

// File: rtl/twowire_slave_fe.sv
module twowire_slave_fe #(
  parameter int         HW_BITS     = 3,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] hw_addr,
  input  logic       be_busy,
  input  logic       wr_refuse,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       addr_valid,
  output logic       addr_rw,
  output logic [2:0] addr_sel,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       rd_req,
  output logic       stop_ev
);

  localparam int         MASK_I  = (7 << (3 - HW_BITS)) & 7;
  localparam logic [2:0] HW_MASK = MASK_I[2:0];

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK, S_HOLD
  } st_t;

  function automatic logic maj3(input logic [2:0] w);
    return (w[0] & w[1]) | (w[0] & w[2]) | (w[1] & w[2]);
  endfunction

  logic [SYNC_STAGES-1:0] scl_s, sda_s;
  logic [2:0] scl_w, sda_w;
  logic       scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_w <= '1;
      sda_w <= '1;
      scl_f <= 1'b1;
      sda_f <= 1'b1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-2:0], scl_in};
      sda_s <= {sda_s[SYNC_STAGES-2:0], sda_in};
      scl_w <= {scl_w[1:0], scl_s[SYNC_STAGES-1]};
      sda_w <= {sda_w[1:0], sda_s[SYNC_STAGES-1]};
      scl_f <= maj3(scl_w);
      sda_f <= maj3(sda_w);
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  wire go       = ~start_c & ~stop_c;

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sr, tx;
  logic       rw, mack, sel;

  wire byte_end = go & scl_fall & (cnt == 4'd8);
  wire match    = (sr[7:4] == DEV_TYPE) && (((sr[3:1] ^ hw_addr) & HW_MASK) == 3'b000);

  assign addr_valid = (st == S_ADDR) & byte_end & match & ~be_busy;
  assign wr_valid   = (st == S_WDATA) & byte_end;
  assign rd_req     = go & scl_fall & (((st == S_AACK) & rw) | ((st == S_RACK) & mack));
  assign stop_ev    = stop_c & sel;
  assign addr_rw    = sr[0];
  assign addr_sel   = sr[3:1];
  assign wr_data    = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sr     <= '0;
      tx     <= '1;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sel    <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sel    <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_f};
            cnt <= cnt + 4'd1;
          end
          if (st == S_ADDR && byte_end) begin
            if (addr_valid) begin
              sda_oe <= 1'b1;
              rw     <= sr[0];
              sel    <= 1'b1;
              st     <= S_AACK;
            end else begin
              st <= S_HOLD;
            end
          end
          if (wr_valid) begin
            if (!wr_refuse) begin
              sda_oe <= 1'b1;
              st     <= S_WACK;
            end else begin
              st <= S_HOLD;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              sda_oe <= ~rd_data[7];
              tx     <= {rd_data[6:0], 1'b1};
              st     <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WDATA;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else begin
              sda_oe <= ~tx[7];
              tx     <= {tx[6:0], 1'b1};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_f;
          if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              sda_oe <= ~rd_data[7];
              tx     <= {rd_data[6:0], 1'b1};
              st     <= S_RDATA;
            end else begin
              st <= S_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

module twowire_slave_fe_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_oe,
  input logic addr_valid,
  input logic wr_valid,
  input logic wr_refuse,
  input logic rd_req,
  input logic stop_ev
);

  assert_oe_clk_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_valid, wr_valid, rd_req, stop_ev}));

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  assert_addr_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> sda_oe);

  assert_write_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_refuse |=> sda_oe);

  assert_refuse_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_refuse |=> !sda_oe);

endmodule

bind twowire_slave_fe twowire_slave_fe_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_oe    (sda_oe),
  .addr_valid(addr_valid),
  .wr_valid  (wr_valid),
  .wr_refuse (wr_refuse),
  .rd_req    (rd_req),
  .stop_ev   (stop_ev)
);

// File: tb/twowire_slave_fe_test.sv
module twowire_slave_fe_test;

  localparam int Q = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic be_busy = 1'b0, wr_refuse = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] rd_n = 8'd0;
  logic sda_oe, addr_valid, addr_rw, wr_valid, rd_req, stop_ev;
  logic [2:0] addr_sel;
  logic [7:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, rd_k = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  twowire_slave_fe #(.HW_BITS(2)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .hw_addr(3'b101), .be_busy(be_busy), .wr_refuse(wr_refuse),
    .rd_data(rd_data), .sda_oe(sda_oe), .addr_valid(addr_valid),
    .addr_rw(addr_rw), .addr_sel(addr_sel), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .stop_ev(stop_ev)
  );

  function automatic logic [7:0] rd_byte(input int k);
    return 8'h3C ^ 8'(k * 29);
  endfunction

  assign rd_data = rd_byte(int'(rd_n));
  always @(posedge clk) if (rd_req) rd_n <= rd_n + 8'd1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic expect_ev(input logic [3:0] kind, input logic [7:0] d, input string tag);
    exp_q.push_back({kind, d});
    tag_q.push_back(tag);
  endtask

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    logic [11:0] got;
    if (rst_n) begin
      if (sda_oe !== prev_oe) chk(!scl_m, "R11", int'(scl_m), 0);
      prev_oe = sda_oe;
      if (addr_valid || wr_valid || rd_req || stop_ev) begin
        got = addr_valid ? {4'd1, 4'd0, addr_sel, addr_rw} :
              wr_valid   ? {4'd2, wr_data} :
              rd_req     ? {4'd3, 8'h00} : {4'd4, 8'h00};
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected strobe", int'(got), 0);
        else begin
          string t;
          logic [11:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(got == e, t, int'(got), int'(e));
        end
      end
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q / 2);
    acked = !sda_line;
    w(Q / 2); scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl_m = 1'b1; w(Q / 2); b[i] = sda_line; w(Q / 2); scl_m = 1'b0;
    end
    w(Q / 2); sda_m = !give_ack; w(Q / 2); scl_m = 1'b1; w(Q); scl_m = 1'b0;
    w(Q / 2); sda_m = 1'b1; w(Q / 2);
  endtask

  task automatic tx_ack(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a;
    send_byte(b, a);
    chk(a == exp_ack, tag, int'(a), int'(exp_ack));
  endtask

  task automatic rx_chk(input bit give_ack, input string tag);
    logic [7:0] b;
    recv_byte(b, give_ack);
    chk(b == rd_byte(rd_k), tag, int'(b), int'(rd_byte(rd_k)));
    rd_k++;
  endtask

  initial begin
    logic [7:0] b;
    w(10);
    rst_n = 1'b1;
    w(10);
    chk(sda_oe == 1'b0, "R1 reset enable", int'(sda_oe), 0);

    // R10: byte with no start
    scl_m = 1'b0; w(Q);
    tx_ack(8'hA8, 1'b0, "R10 unframed byte");
    bus_stop();

    // R3/R5: matching write of three bytes
    expect_ev(4'd1, 8'h08, "R3 addr strobe");
    expect_ev(4'd2, 8'h3C, "R5 byte0");
    expect_ev(4'd2, 8'h96, "R5 byte1");
    expect_ev(4'd2, 8'h01, "R5 byte2");
    expect_ev(4'd4, 8'h00, "R2 stop strobe");
    bus_start();
    tx_ack(8'hA8, 1'b1, "R3 select ack");
    tx_ack(8'h3C, 1'b1, "R5 ack0");
    tx_ack(8'h96, 1'b1, "R5 ack1");
    tx_ack(8'h01, 1'b1, "R5 ack2");
    bus_stop();
    chk(sda_oe == 1'b0, "R2 released", int'(sda_oe), 0);

    // R4: page bit set
    expect_ev(4'd1, 8'h0A, "R4 page strobe");
    expect_ev(4'd2, 8'h55, "R4 byte");
    expect_ev(4'd4, 8'h00, "R4 stop");
    bus_start();
    tx_ack(8'hAA, 1'b1, "R4 page select ack");
    tx_ack(8'h55, 1'b1, "R4 data ack");
    bus_stop();

    // R3: wrong hardware bit, wrong type
    bus_start();
    tx_ack(8'hA0, 1'b0, "R3 hw mismatch");
    tx_ack(8'h12, 1'b0, "R3 silent after mismatch");
    bus_stop();
    bus_start();
    tx_ack(8'hB8, 1'b0, "R3 type mismatch");
    bus_stop();

    // R8: busy
    be_busy = 1'b1;
    bus_start();
    tx_ack(8'hA8, 1'b0, "R8 busy nack");
    bus_stop();
    be_busy = 1'b0;

    // R6: refused byte
    expect_ev(4'd1, 8'h08, "R6 addr");
    expect_ev(4'd2, 8'h10, "R6 first byte");
    expect_ev(4'd2, 8'h77, "R6 refused byte");
    expect_ev(4'd4, 8'h00, "R6 stop");
    bus_start();
    tx_ack(8'hA8, 1'b1, "R6 select ack");
    tx_ack(8'h10, 1'b1, "R6 accepted ack");
    wr_refuse = 1'b1;
    tx_ack(8'h77, 1'b0, "R6 refused nack");
    tx_ack(8'h88, 1'b0, "R6 later byte nack");
    bus_stop();
    wr_refuse = 1'b0;

    // R9/R7: random read via repeated start
    expect_ev(4'd1, 8'h08, "R9 write addr");
    expect_ev(4'd2, 8'h00, "R9 word");
    expect_ev(4'd1, 8'h09, "R9 read addr, no stop before");
    expect_ev(4'd3, 8'h00, "R7 req0");
    expect_ev(4'd3, 8'h00, "R7 req1");
    expect_ev(4'd4, 8'h00, "R7 stop");
    bus_start();
    tx_ack(8'hA8, 1'b1, "R9 select ack");
    tx_ack(8'h00, 1'b1, "R9 word ack");
    bus_start();
    tx_ack(8'hA9, 1'b1, "R9 read select ack");
    rx_chk(1'b1, "R7 read byte0");
    rx_chk(1'b0, "R7 read byte1");
    recv_byte(b, 1'b0);
    chk(b == 8'hFF, "R7 released after nack", int'(b), 8'hFF);
    bus_stop();

    // R7: current-address single read
    expect_ev(4'd1, 8'h09, "R7 cur addr");
    expect_ev(4'd3, 8'h00, "R7 cur req");
    expect_ev(4'd4, 8'h00, "R7 cur stop");
    bus_start();
    tx_ack(8'hA9, 1'b1, "R7 cur select ack");
    rx_chk(1'b0, "R7 cur byte");
    bus_stop();

    // R2: stop in the middle of a byte
    expect_ev(4'd1, 8'h08, "R2 addr");
    expect_ev(4'd4, 8'h00, "R2 mid-byte stop");
    bus_start();
    tx_ack(8'hA8, 1'b1, "R2 select ack");
    send_bits(8'hF0, 4);
    bus_stop();
    chk(sda_oe == 1'b0, "R2 idle after abort", int'(sda_oe), 0);
    expect_ev(4'd1, 8'h08, "R2 recovery addr");
    expect_ev(4'd4, 8'h00, "R2 recovery stop");
    bus_start();
    tx_ack(8'hA8, 1'b1, "R2 recovery ack");
    bus_stop();

    w(20);
    chk(exp_q.size() == 0, "R2 all strobes seen", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1 watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule